// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers limit-violation levels from a hardware monitor and keeps them in two 8-bit status registers. Bank A holds seven sources: temperature channels and supply rails. Bank B holds six sources: fan-speed faults, a 12 V rail fault and an overtemperature level. A status bit is set as soon as its source goes out of limit. A sticky bit is cleared only by a read that finds its condition already gone. The overtemperature bit is the exception: it simply follows its level.

The block drives an open-drain style, active-low alert pin. The pin goes low while any source that is not masked has its status bit set. Two mask registers choose which sources may pull the alert. A mask never stops a status bit from being set. Bit 7 of bank A is a summary of all of bank B, and bit 7 of mask A silences all of bank B at once.

Host software typically works as follows. It sees the alert and reads the status. It masks the source that fired and deals with it. It then polls until the bit clears and unmasks the source again, which rearms the alert.

The register port is a plain strobe interface with no back-pressure. A read or a write is accepted in every cycle its strobe is high, and read data appears one clock after the strobe.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, both status banks and both mask registers read 0 and `alert_no` is 1.
- R2: A high level on a condition input sets its status bit at the next clock edge. Reads use `rd_stb_i`, and data is on `rd_data_o` one cycle later. Address 0x41 returns bank A: bit 6 remote 2 temperature, bit 5 local temperature, bit 4 remote 1 temperature, bit 3 5 V, bit 2 core supply, bit 1 processor supply, bit 0 2.5 V. Address 0x42 returns bank B: bits 5..2 fans 4..1, bit 1 overtemperature, bit 0 12 V. Any other unmapped address reads 0.
- R3: A sticky bit stays set after its condition drops. It is cleared by a read of its bank that happens once the condition has gone, so the next read returns 0.
- R4: A read made while a condition is still high leaves that bit set.
- R5: Bank B bit 1 (overtemperature) is not sticky. It drops one edge after its level falls, with no read needed.
- R6: `alert_no` goes to 0 two edges after an unmasked source rises. It stays at 0 until every unmasked status bit has cleared, and returns to 1 on the edge after that.
- R7: A set mask bit stops its source from pulling the alert, but its status bit is still set and read normally.
- R8: Mask A bit 7 = 1 stops every bank B source from pulling the alert.
- R9: Bank A bit 7 reads 1 whenever any bank B status bit is set. Reading bank A does not clear bank B.
- R10: Mask A is at address 0x74 (8 bits) and mask B at 0x75 (bits 5..0 only, bits 7..6 read 0). Both are written through `wr_en_i` and read back through the read port without side effects.
- R11: The clear from a read is applied on the edge after the capture. A condition that is high at that edge keeps its bit set.
- R12: A mask bit cleared after its status bit has cleared leaves the alert released, and a new event from that source pulls the alert low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cond_a_i | input | 7 | Bank A out-of-limit levels |
| cond_b_i | input | 6 | Bank B out-of-limit levels |
| rd_stb_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data, registered |
| wr_en_i | input | 1 | Mask write enable |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| alert_no | output | 1 | Alert, 0 = asserted, 1 = released |

## Verification
The hardest case to reach is a new event that coincides with the clear edge of a read. It needs a level that was already captured as set, then dropped, and then raised again in exactly the cycle after the capture. The bench drives that pattern by hand around a single read strobe. It then confirms with two more reads that the bit survived once and clears afterwards. The mask rearm sequence is also driven step by step (assert, mask, drop, read, unmask, re-fire), with the alert pin checked after every step.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int unsigned DW     = 8;
  localparam int unsigned AW     = 8;
  localparam int unsigned SRC_A  = 7;
  localparam int unsigned SRC_B  = 6;
  localparam logic [AW-1:0] ADDR_STAT_A = 8'h41;
  localparam logic [AW-1:0] ADDR_STAT_B = 8'h42;
  localparam logic [AW-1:0] ADDR_MASK_A = 8'h74;
  localparam logic [AW-1:0] ADDR_MASK_B = 8'h75;
  // bank B bit that follows its level instead of latching
  localparam logic [SRC_B-1:0] B_LEVEL_BITS = 6'b000010;
endpackage

// File: rtl/isc_status_bank.sv
module isc_status_bank #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] LEVEL_BITS = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (LEVEL_BITS[i]) begin : g_level
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stat_o[i] <= 1'b0;
        else         stat_o[i] <= cond_i[i];
      end
    end else begin : g_sticky
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          stat_o[i] <= 1'b0;
        else
          stat_o[i] <= cond_i[i] | (stat_o[i] & ~(clr_en_i & clr_bits_i[i]));
      end
    end
  end
endmodule

// File: rtl/isc_mask_regs.sv
module isc_mask_regs #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8,
  parameter int unsigned MB = 6,
  parameter logic [AW-1:0] ADDR_A = 8'h74,
  parameter logic [AW-1:0] ADDR_B = 8'h75
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] mask_a_o,
  output logic [MB-1:0] mask_b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_a_o <= '0;
      mask_b_o <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_A) mask_a_o <= wr_data_i;
      if (wr_addr_i == ADDR_B) mask_b_o <= wr_data_i[MB-1:0];
    end
  end
endmodule

// File: rtl/isc_alert_gen.sv
module isc_alert_gen #(
  parameter int unsigned SA = 7,
  parameter int unsigned SB = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SA-1:0] st_a_i,
  input  logic [SB-1:0] st_b_i,
  input  logic [SA:0]   mask_a_i,
  input  logic [SB-1:0] mask_b_i,
  output logic          alert_no
);
  logic hit_a, hit_b, req;

  always_comb begin
    hit_a = |(st_a_i & ~mask_a_i[SA-1:0]);
    // top bit of mask A silences the whole of bank B
    hit_b = ~mask_a_i[SA] & (|(st_b_i & ~mask_b_i));
    req   = hit_a | hit_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_no <= 1'b1;
    else         alert_no <= ~req;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned ADDR_W = AW,
  parameter int unsigned NSRC_A = SRC_A,
  parameter int unsigned NSRC_B = SRC_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC_A-1:0] cond_a_i,
  input  logic [NSRC_B-1:0] cond_b_i,
  input  logic              rd_stb_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              alert_no
);
  localparam int unsigned PAD_B = DATA_W - NSRC_B;

  logic [NSRC_A-1:0] st_a, cap_a_q;
  logic [NSRC_B-1:0] st_b, cap_b_q;
  logic              clr_a_q, clr_b_q;
  logic [DATA_W-1:0] mask_a;
  logic [NSRC_B-1:0] mask_b;
  logic [DATA_W-1:0] rd_mux;

  isc_status_bank #(.W(NSRC_A), .LEVEL_BITS('0)) u_bank_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_a_i),
    .clr_en_i(clr_a_q), .clr_bits_i(cap_a_q), .stat_o(st_a)
  );

  isc_status_bank #(.W(NSRC_B), .LEVEL_BITS(B_LEVEL_BITS)) u_bank_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .cond_i(cond_b_i),
    .clr_en_i(clr_b_q), .clr_bits_i(cap_b_q), .stat_o(st_b)
  );

  isc_mask_regs #(
    .DW(DATA_W), .AW(ADDR_W), .MB(NSRC_B),
    .ADDR_A(ADDR_MASK_A), .ADDR_B(ADDR_MASK_B)
  ) u_masks (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .mask_a_o(mask_a), .mask_b_o(mask_b)
  );

  isc_alert_gen #(.SA(NSRC_A), .SB(NSRC_B)) u_alert (
    .clk_i(clk_i), .rst_ni(rst_ni), .st_a_i(st_a), .st_b_i(st_b),
    .mask_a_i(mask_a[NSRC_A:0]), .mask_b_i(mask_b), .alert_no(alert_no)
  );

  always_comb begin
    unique case (rd_addr_i)
      ADDR_STAT_A: rd_mux = {|st_b, st_a};
      ADDR_STAT_B: rd_mux = {{PAD_B{1'b0}}, st_b};
      ADDR_MASK_A: rd_mux = mask_a;
      ADDR_MASK_B: rd_mux = {{PAD_B{1'b0}}, mask_b};
      default:     rd_mux = '0;
    endcase
  end

  // capture on the strobe edge, clear on the following edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      clr_a_q   <= 1'b0;
      clr_b_q   <= 1'b0;
      cap_a_q   <= '0;
      cap_b_q   <= '0;
    end else begin
      clr_a_q <= rd_stb_i && (rd_addr_i == ADDR_STAT_A);
      clr_b_q <= rd_stb_i && (rd_addr_i == ADDR_STAT_B);
      if (rd_stb_i) begin
        rd_data_o <= rd_mux;
        cap_a_q   <= st_a;
        cap_b_q   <= st_b;
      end
    end
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int unsigned NA = 7,
  parameter int unsigned NB = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [NA-1:0] cond_a_i,
  input logic [NB-1:0] cond_b_i,
  input logic [NA-1:0] st_a,
  input logic [NB-1:0] st_b,
  input logic [NA:0]   mask_a,
  input logic [NB-1:0] mask_b,
  input logic          clr_a_q,
  input logic          alert_no
);
  // R2
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st_a & $past(cond_a_i)) == $past(cond_a_i)));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_a_q |=> (($past(st_a) & ~st_a) == '0));

  // R5
  ot_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_b_i[1] |=> !st_b[1]);

  // R6
  alert_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(st_a & ~mask_a[NA-1:0])) |=> !alert_no);

  // R7
  alert_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_a & ~mask_a[NA-1:0]) == '0 && (mask_a[NA] || (st_b & ~mask_b) == '0))
      |=> alert_no);
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.NA(NSRC_A), .NB(NSRC_B)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cond_a_i(cond_a_i), .cond_b_i(cond_b_i),
  .st_a(st_a), .st_b(st_b), .mask_a(mask_a[NSRC_A:0]), .mask_b(mask_b),
  .clr_a_q(clr_a_q), .alert_no(alert_no)
);

// File: tb/sim_irq_status_ctrl.sv
`timescale 1ns/1ps
module sim_irq_status_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cond_a = '0;
  logic [5:0] cond_b = '0;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       alert_n;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_status_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cond_a_i(cond_a), .cond_b_i(cond_b),
    .rd_stb_i(rd_stb), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .alert_no(alert_n)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // read: strobe edge captures, next edge applies the clear
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_stb = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_stb = 1'b0;
    d = rd_data;
    cyc(1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 alert", {7'd0, alert_n}, 8'h01);
    rd(8'h41, d); check("R1 bank A", d, 8'h00);
    rd(8'h42, d); check("R1 bank B", d, 8'h00);
    rd(8'h74, d); check("R1 mask A", d, 8'h00);
    rd(8'h75, d); check("R1 mask B", d, 8'h00);
  endtask

  task automatic t_sticky;
    logic [7:0] d;
    cond_a = 7'h20; cyc(1); cond_a = '0; cyc(2);
    check("R6 alert low after pulse", {7'd0, alert_n}, 8'h00);
    rd(8'h41, d); check("R2 local temp bit", d, 8'h20);
    cyc(1);
    check("R6 alert released", {7'd0, alert_n}, 8'h01);
    rd(8'h41, d); check("R3 cleared after read", d, 8'h00);
  endtask

  task automatic t_active_read;
    logic [7:0] d;
    cond_a = 7'h01; cyc(2);
    rd(8'h41, d); check("R2 2.5V bit", d, 8'h01);
    rd(8'h41, d); check("R4 kept while active", d, 8'h01);
    cond_a = '0; cyc(1);
    rd(8'h41, d); check("R3 still sticky", d, 8'h01);
    rd(8'h41, d); check("R3 now clear", d, 8'h00);
    rd(8'h10, d); check("R2 unmapped addr", d, 8'h00);
  endtask

  task automatic t_overtemp;
    logic [7:0] d;
    cond_b = 6'h02; cyc(2);
    check("R5 alert on overtemp", {7'd0, alert_n}, 8'h00);
    rd(8'h42, d); check("R5 overtemp set", d, 8'h02);
    cond_b = '0; cyc(1);
    rd(8'h42, d); check("R5 overtemp not sticky", d, 8'h00);
    check("R5 alert released", {7'd0, alert_n}, 8'h01);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(8'h74, 8'h10);
    cond_a = 7'h10; cyc(1); cond_a = '0; cyc(2);
    check("R7 masked alert stays high", {7'd0, alert_n}, 8'h01);
    rd(8'h41, d); check("R7 status still set", d, 8'h10);
    rd(8'h41, d); check("R7 clears normally", d, 8'h00);
    wr(8'h74, 8'h00);
  endtask

  task automatic t_cascade;
    logic [7:0] d;
    cond_b = 6'h04; cyc(2);
    check("R8 unmasked fan alerts", {7'd0, alert_n}, 8'h00);
    cond_b = '0; rd(8'h42, d); rd(8'h42, d); cyc(1);
    wr(8'h74, 8'h80);
    cond_b = 6'h08; cyc(1); cond_b = '0; cyc(2);
    check("R8 bank B masked", {7'd0, alert_n}, 8'h01);
    rd(8'h41, d); check("R9 summary bit", d, 8'h80);
    rd(8'h42, d); check("R9 bank B kept after A read", d, 8'h08);
    rd(8'h41, d); check("R9 summary gone", d, 8'h00);
    wr(8'h74, 8'h00);
  endtask

  task automatic t_maskrw;
    logic [7:0] d;
    wr(8'h74, 8'hA5); rd(8'h74, d); check("R10 mask A", d, 8'hA5);
    wr(8'h75, 8'hFF); rd(8'h75, d); check("R10 mask B width", d, 8'h3F);
    rd(8'h75, d); check("R10 read no side effect", d, 8'h3F);
    wr(8'h74, 8'h00); wr(8'h75, 8'h00);
  endtask

  task automatic t_same_edge;
    logic [7:0] d;
    cond_b = 6'h01; cyc(1); cond_b = '0; cyc(1);
    rd_stb = 1'b1; rd_addr = 8'h42;
    @(posedge clk); @(negedge clk);
    rd_stb = 1'b0;
    check("R11 captured", rd_data, 8'h01);
    cond_b = 6'h01;
    @(posedge clk); @(negedge clk);
    cond_b = '0;
    cyc(1);
    rd(8'h42, d); check("R11 new event survives clear", d, 8'h01);
    rd(8'h42, d); check("R11 then clears", d, 8'h00);
  endtask

  task automatic t_rearm;
    logic [7:0] d;
    cond_a = 7'h20; cyc(2);
    check("R12 alert low", {7'd0, alert_n}, 8'h00);
    rd(8'h41, d);
    wr(8'h74, 8'h20);
    check("R12 masked releases", {7'd0, alert_n}, 8'h01);
    cond_a = '0; cyc(1);
    rd(8'h41, d); check("R12 status seen", d, 8'h20);
    wr(8'h74, 8'h00);
    check("R12 unmask keeps released", {7'd0, alert_n}, 8'h01);
    cond_a = 7'h20; cyc(2);
    check("R12 rearmed", {7'd0, alert_n}, 8'h00);
    cond_a = '0; cyc(1); rd(8'h41, d); cyc(1);
    check("R12 final release", {7'd0, alert_n}, 8'h01);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_sticky();
    t_active_read();
    t_overtemp();
    t_mask();
    t_cascade();
    t_maskrw();
    t_same_edge();
    t_rearm();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule